// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor built around a single 16-bit accumulator and a one-bit carry/link flag. Program and data share one memory of 4096 words of 16 bits. The core reaches that memory through a synchronous port. It drives a 12-bit address, 16-bit write data and a write enable. Read data arrives one clock after the address is presented. Each instruction runs in steps that a phase register and a step counter sequence. The phases are fetch, decode, an optional indirect phase and execute. No phase uses the memory more than once per cycle.

An instruction word carries three fields. Bit 15 is the mode bit. Bits 14-12 are the operation code. Bits 11-0 are an address or a micro-operation mask. Operation codes 0 to 6 reference memory, either directly or through one level of indirection. Operation code 7 never touches memory. With mode 0 it runs accumulator and flag micro-operations. With mode 1 it talks to an external character I/O and interrupt unit through byte-wide input and output paths, ready flags and an interrupt-enable output. After reset the core starts fetching at address 0. A halt instruction stops it until the next reset.

Top module: `accum_cpu`

## Requirements
- R1: While reset (rstN low) is held, halted and memWe are 0, and memAddr shows the program counter, which is 0. Asserting reset clears halted. The accumulator, carry flag, outData and intEnable reset to 0.
- R2: Memory reads have one cycle of latency. Operation codes 0 (AND), 1 (ADD) and 2 (LDA) with bit 15 = 0 use bits 11-0 as the operand address. AND leaves the bitwise AND of the accumulator and the operand. LDA loads the operand.
- R3: ADD forms the 17-bit sum of the accumulator and the operand. The low 16 bits go to the accumulator and the carry-out goes to the carry flag. A sum with no carry clears the flag.
- R4: For operation codes 0-6 with bit 15 = 1, the word at bits 11-0 is read first. Its bits 11-0 become the effective address, and its bits 15-12 are ignored.
- R5: STA (code 3) writes the accumulator to the effective address and leaves the accumulator unchanged.
- R6: BUN (code 4) continues execution at the effective address.
- R7: BSA (code 5) writes the address of the next instruction (zero-extended) to the effective address. Execution then continues at the effective address plus one.
- R8: ISZ (code 6) writes the memory word at the effective address plus one, modulo 2^16. When that result is 0, the next instruction is skipped.
- R9: Word 0x7xxx with a single mask bit set gives these accumulator operations: 0x800 clear AC, 0x400 clear carry, 0x200 complement AC, 0x100 complement carry, 0x080 rotate {carry,AC} right, 0x040 rotate {AC,carry} left, and 0x020 increment AC. Increment does not change the carry flag.
- R10: Word 0x7xxx skip tests work on the accumulator value before the instruction. They are 0x010 (bit 15 = 0), 0x008 (bit 15 = 1), 0x004 (AC = 0) and 0x002 (carry = 0). A skip that is taken passes over exactly one instruction.
- R11: Word 0x7001 sets halted three clocks after reset release when it sits at address 0. From then on there are no more fetches, no writes and no state changes until reset.
- R12: Word 0xFxxx runs I/O operations. 0x800 loads inpData into AC bits 7-0, keeps bits 15-8 and pulses inpAck for one cycle. 0x400 copies AC bits 7-0 to outData and pulses outStrobe for one cycle. 0x200 skips if inpFlag is high, and 0x100 skips if outFlag is high. 0x080 sets intEnable and 0x040 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 12 | Memory word address |
| memRdata | input | 16 | Read data, valid one cycle after the address |
| memWdata | output | 16 | Write data |
| memWe | output | 1 | Write enable for the current cycle |
| halted | output | 1 | Core has stopped after a halt instruction |
| inpData | input | 8 | Character from the input device |
| inpFlag | input | 1 | Input device has a character ready |
| inpAck | output | 1 | One-cycle pulse: input character consumed |
| outData | output | 8 | Character register toward the output device |
| outFlag | input | 1 | Output device ready for a character |
| outStrobe | output | 1 | One-cycle pulse: outData was loaded |
| intEnable | output | 1 | Interrupt enable flag |

## Verification
Internal state can only be seen through the ports. The stimulus therefore consists of short programs placed in a bench-side memory while reset is held. Each program stores its accumulator results with STA. Skip outcomes are observed by putting an ISZ on a counter that starts at 1 right after each skip test, so a skipped ISZ leaves 1 and an executed one leaves 2. The hardest sequences to reach are the ISZ wrap from 0xFFFF to 0 together with its skip, and a subroutine call through BSA that returns through an indirect BUN on the stored return word. Both need several instructions to cooperate, and they are checked by their effects on memory.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_ADD   = 3'd1,
    OP_LDA   = 3'd2,
    OP_STA   = 3'd3,
    OP_BUN   = 3'd4,
    OP_BSA   = 3'd5,
    OP_ISZ   = 3'd6,
    OP_MICRO = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    WD_AC,
    WD_PC,
    WD_DR
  } wsel_e;

  typedef enum logic [1:0] {
    AC_NONE,
    AC_AND,
    AC_ADD,
    AC_LDA
  } acop_e;

  // mask bit positions for register micro-operations (opcode 7, mode 0)
  localparam int MB_CLA = 11;
  localparam int MB_CLE = 10;
  localparam int MB_CMA = 9;
  localparam int MB_CME = 8;
  localparam int MB_CIR = 7;
  localparam int MB_CIL = 6;
  localparam int MB_INC = 5;
  localparam int MB_SPA = 4;
  localparam int MB_SNA = 3;
  localparam int MB_SZA = 2;
  localparam int MB_SZE = 1;
  localparam int MB_HLT = 0;

  // mask bit positions for I/O operations (opcode 7, mode 1)
  localparam int IB_INP = 11;
  localparam int IB_OUT = 10;
  localparam int IB_SKI = 9;
  localparam int IB_SKO = 8;
  localparam int IB_ION = 7;
  localparam int IB_IOF = 6;

  typedef struct packed {
    logic  addrPc;     // memory address from program counter
    logic  loadIr;     // capture instruction and its address field
    logic  incPc;      // advance program counter
    logic  loadPc;     // program counter <= address register
    logic  loadArMem;  // address register <= read data (indirect)
    logic  incAr;      // address register + 1
    logic  memWe;      // memory write this cycle
    wsel_e wsel;       // write data source
    acop_e acOp;       // accumulator memory operation
    logic  loadDrInc;  // data register <= read data + 1
    logic  skipDrZero; // skip when data register is zero
    logic  regExec;    // run register micro-operations
    logic  ioExec;     // run I/O micro-operations
  } ctrl_t;

endpackage

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
  import accum_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irMode,
  input  logic [2:0] irOp,
  input  logic       irHalt,
  output ctrl_t      st,
  output logic       halted
);

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_DECODE,
    PH_INDIRECT,
    PH_EXECUTE,
    PH_HALT
  } phase_e;

  phase_e     phase, nxtPhase;
  logic [1:0] step, nxtStep;
  logic       done;

  always_comb begin
    st       = '0;
    nxtPhase = phase;
    nxtStep  = step + 2'd1;
    done     = 1'b0;
    unique case (phase)
      PH_FETCH: begin
        st.addrPc = 1'b1;
        if (step != 2'd0) begin
          st.loadIr = 1'b1;
          st.incPc  = 1'b1;
          nxtPhase  = PH_DECODE;
          nxtStep   = 2'd0;
        end
      end
      PH_DECODE: begin
        nxtStep = 2'd0;
        if (irOp == OP_MICRO) begin
          if (irMode) st.ioExec  = 1'b1;
          else        st.regExec = 1'b1;
          nxtPhase = (!irMode && irHalt) ? PH_HALT : PH_FETCH;
        end else if (irMode) begin
          nxtPhase = PH_INDIRECT;
        end else begin
          nxtPhase = PH_EXECUTE;
        end
      end
      PH_INDIRECT: begin
        if (step != 2'd0) begin
          st.loadArMem = 1'b1;
          nxtPhase     = PH_EXECUTE;
          nxtStep      = 2'd0;
        end
      end
      PH_EXECUTE: begin
        unique case (irOp)
          OP_AND, OP_ADD, OP_LDA: begin
            if (step != 2'd0) begin
              st.acOp = (irOp == OP_AND) ? AC_AND :
                        (irOp == OP_ADD) ? AC_ADD : AC_LDA;
              done = 1'b1;
            end
          end
          OP_STA: begin
            st.memWe = 1'b1;
            st.wsel  = WD_AC;
            done     = 1'b1;
          end
          OP_BUN: begin
            st.loadPc = 1'b1;
            done      = 1'b1;
          end
          OP_BSA: begin
            if (step == 2'd0) begin
              st.memWe = 1'b1;
              st.wsel  = WD_PC;
              st.incAr = 1'b1;
            end else begin
              st.loadPc = 1'b1;
              done      = 1'b1;
            end
          end
          OP_ISZ: begin
            if (step == 2'd1) begin
              st.loadDrInc = 1'b1;
            end else if (step == 2'd2) begin
              st.memWe      = 1'b1;
              st.wsel       = WD_DR;
              st.skipDrZero = 1'b1;
              done          = 1'b1;
            end
          end
          default: done = 1'b1;
        endcase
        if (done) begin
          nxtPhase = PH_FETCH;
          nxtStep  = 2'd0;
        end
      end
      PH_HALT: nxtStep = 2'd0;
      default: begin
        nxtPhase = PH_FETCH;
        nxtStep  = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_FETCH;
      step  <= 2'd0;
    end else begin
      phase <= nxtPhase;
      step  <= nxtStep;
    end
  end

  assign halted = (phase == PH_HALT);

  // R11: once stopped, the core stays stopped until reset
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HALT) |=> (phase == PH_HALT));

  // R11: a stopped core issues no writes and no program-counter steps
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!st.memWe && !st.incPc && !st.loadIr));

  // R2: at most one memory-side action per cycle
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.memWe, st.loadIr, st.loadArMem, st.loadDrInc}));

endmodule

// File: rtl/accum_cpu_dpath.sv
module accum_cpu_dpath
  import accum_cpu_pkg::*;
#(
  parameter int AddrW = 12,
  parameter int DataW = 16,
  parameter int IoW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            st,
  input  logic [DataW-1:0] memRdata,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  output logic [DataW-1:0] irOut,
  input  logic [IoW-1:0]   inpData,
  input  logic             inpFlag,
  input  logic             outFlag,
  output logic             inpAck,
  output logic             outStrobe,
  output logic [IoW-1:0]   outData,
  output logic             intEnable
);

  localparam int Msb = DataW - 1;

  logic [AddrW-1:0] pc, ar;
  logic [DataW-1:0] ir, ac, dr;
  logic             eFlag;
  logic [IoW-1:0]   outReg;
  logic             ienReg;

  logic [DataW-1:0] microAc;
  logic             microE;
  logic             regSkip, ioSkip, drZero, pcStep;
  logic [DataW:0]   sum;

  // register micro-operations, applied in mask order
  always_comb begin
    microAc = ac;
    microE  = eFlag;
    if (ir[MB_CLA]) microAc = '0;
    if (ir[MB_CLE]) microE  = 1'b0;
    if (ir[MB_CMA]) microAc = ~microAc;
    if (ir[MB_CME]) microE  = ~microE;
    if (ir[MB_CIR]) begin
      {microAc, microE} = {microE, microAc[Msb:0]};
    end
    if (ir[MB_CIL]) begin
      {microE, microAc} = {microAc, microE};
    end
    if (ir[MB_INC]) microAc = microAc + 1'b1;
  end

  assign regSkip = (ir[MB_SPA] && !ac[Msb]) ||
                   (ir[MB_SNA] &&  ac[Msb]) ||
                   (ir[MB_SZA] && (ac == '0)) ||
                   (ir[MB_SZE] && !eFlag);
  assign ioSkip  = (ir[IB_SKI] && inpFlag) || (ir[IB_SKO] && outFlag);
  assign drZero  = (dr == '0);
  assign sum     = {1'b0, ac} + {1'b0, memRdata};
  assign pcStep  = st.incPc ||
                   (st.skipDrZero && drZero) ||
                   (st.regExec && regSkip) ||
                   (st.ioExec && ioSkip);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      ar     <= '0;
      ir     <= '0;
      ac     <= '0;
      dr     <= '0;
      eFlag  <= 1'b0;
      outReg <= '0;
      ienReg <= 1'b0;
    end else begin
      if (st.loadIr) begin
        ir <= memRdata;
        ar <= memRdata[AddrW-1:0];
      end else if (st.loadArMem) begin
        ar <= memRdata[AddrW-1:0];
      end else if (st.incAr) begin
        ar <= ar + 1'b1;
      end

      if (st.loadPc)     pc <= ar;
      else if (pcStep)   pc <= pc + 1'b1;

      if (st.loadDrInc)  dr <= memRdata + 1'b1;

      unique case (st.acOp)
        AC_AND: ac <= ac & memRdata;
        AC_ADD: {eFlag, ac} <= sum;
        AC_LDA: ac <= memRdata;
        default: begin
          if (st.regExec) begin
            ac    <= microAc;
            eFlag <= microE;
          end else if (st.ioExec && ir[IB_INP]) begin
            ac <= {ac[Msb:IoW], inpData};
          end
        end
      endcase

      if (st.ioExec && ir[IB_OUT]) outReg <= ac[IoW-1:0];
      if (st.ioExec) begin
        if (ir[IB_ION])      ienReg <= 1'b1;
        else if (ir[IB_IOF]) ienReg <= 1'b0;
      end
    end
  end

  assign memAddr = st.addrPc ? pc : ar;

  always_comb begin
    unique case (st.wsel)
      WD_PC:   memWdata = {{(DataW-AddrW){1'b0}}, pc};
      WD_DR:   memWdata = dr;
      default: memWdata = ac;
    endcase
  end

  assign irOut     = ir;
  assign inpAck    = st.ioExec && ir[IB_INP];
  assign outStrobe = st.ioExec && ir[IB_OUT];
  assign outData   = outReg;
  assign intEnable = ienReg;

  // R3: the carry flag moves only through ADD or a register micro-operation
  p_carry_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    (eFlag != $past(eFlag)) |-> $past(st.acOp == AC_ADD || st.regExec));

  // R6: the program counter moves only on a fetch, branch or skip request
  p_pc_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pc != $past(pc)) |-> $past(st.incPc || st.loadPc || st.skipDrZero ||
                                st.regExec || st.ioExec));

  // R5: a store leaves the accumulator as it was
  p_ac_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.memWe) |-> (ac == $past(ac)));

  // R12: the output character changes only after an output strobe
  p_out_src_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outData != $past(outData)) |-> $past(outStrobe));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int AddrW = 12,
  parameter int DataW = 16,
  parameter int IoW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [AddrW-1:0] memAddr,
  input  logic [DataW-1:0] memRdata,
  output logic [DataW-1:0] memWdata,
  output logic             memWe,
  output logic             halted,
  input  logic [IoW-1:0]   inpData,
  input  logic             inpFlag,
  output logic             inpAck,
  output logic [IoW-1:0]   outData,
  input  logic             outFlag,
  output logic             outStrobe,
  output logic             intEnable
);

  ctrl_t            st;
  logic [DataW-1:0] irWord;

  accum_cpu_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .irMode (irWord[DataW-1]),
    .irOp   (irWord[DataW-2:DataW-4]),
    .irHalt (irWord[MB_HLT]),
    .st     (st),
    .halted (halted)
  );

  accum_cpu_dpath #(
    .AddrW (AddrW),
    .DataW (DataW),
    .IoW   (IoW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .irOut     (irWord),
    .inpData   (inpData),
    .inpFlag   (inpFlag),
    .outFlag   (outFlag),
    .inpAck    (inpAck),
    .outStrobe (outStrobe),
    .outData   (outData),
    .intEnable (intEnable)
  );

  assign memWe = st.memWe;

endmodule

// File: tb/accum_cpu_tb.sv
module accum_cpu_tb_top;

  localparam int MemDepth = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memRdata;
  logic [15:0] memWdata;
  logic        memWe;
  logic        halted;
  logic [7:0]  inpData = 8'h00;
  logic        inpFlag = 1'b0;
  logic        inpAck;
  logic [7:0]  outData;
  logic        outFlag = 1'b0;
  logic        outStrobe;
  logic        intEnable;

  logic [15:0] mem [MemDepth];

  int nChecks = 0;
  int nFail   = 0;
  int ackCnt  = 0;
  int strbCnt = 0;
  int haltWr  = 0;

  always #10 clk = ~clk;

  accum_cpu dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .memAddr   (memAddr),
    .memRdata  (memRdata),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .halted    (halted),
    .inpData   (inpData),
    .inpFlag   (inpFlag),
    .inpAck    (inpAck),
    .outData   (outData),
    .outFlag   (outFlag),
    .outStrobe (outStrobe),
    .intEnable (intEnable)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[8:0]] <= memWdata;
    memRdata <= mem[memAddr[8:0]];
    if (rstN && inpAck)    ackCnt  <= ackCnt + 1;
    if (rstN && outStrobe) strbCnt <= strbCnt + 1;
    if (rstN && halted && memWe) haltWr <= haltWr + 1;
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic begin_prog();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MemDepth; i++) mem[i] = 16'h0000;
    ackCnt  = 0;
    strbCnt = 0;
    haltWr  = 0;
  endtask

  task automatic go(input int limit, output int cyc);
    rstN = 1'b1;
    cyc  = 0;
    while (!halted && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) check("run", "halt reached", 16'h0, 16'h1);
  endtask

  task automatic t_reset_halt();
    int cyc;
    begin_prog();
    mem[0]     = 16'h7001;  // halt
    mem[1]     = 16'h3040;  // store, must never run
    mem[12'h40] = 16'h1111;
    check("R1", "halted in reset", {15'b0, halted}, 16'h0);
    check("R1", "memWe in reset", {15'b0, memWe}, 16'h0);
    check("R1", "fetch address", {4'b0, memAddr}, 16'h0000);
    go(50, cyc);
    check("R11", "cycles to halt", cyc[15:0], 16'd3);
    repeat (20) @(negedge clk);
    check("R11", "halted holds", {15'b0, halted}, 16'h1);
    check("R11", "no write after halt", haltWr[15:0], 16'h0);
    check("R11", "instruction after halt not run", mem[12'h40], 16'h1111);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "reset clears halted", {15'b0, halted}, 16'h0);
    check("R1", "outData reset", {8'h0, outData}, 16'h0);
    check("R1", "intEnable reset", {15'b0, intEnable}, 16'h0);
  endtask

  task automatic t_direct();
    int cyc;
    begin_prog();
    mem[0]  = 16'h2040; // LDA 40
    mem[1]  = 16'h1041; // ADD 41 -> carry
    mem[2]  = 16'h3050; // STA 50
    mem[3]  = 16'h7800; // CLA
    mem[4]  = 16'h7040; // CIL brings carry in
    mem[5]  = 16'h3051;
    mem[6]  = 16'h2042; // LDA 42
    mem[7]  = 16'h0043; // AND 43
    mem[8]  = 16'h3052;
    mem[9]  = 16'h1042; // ADD without carry
    mem[10] = 16'h7040; // CIL
    mem[11] = 16'h3053;
    mem[12] = 16'h7001;
    mem[12'h40] = 16'h8000;
    mem[12'h41] = 16'h8001;
    mem[12'h42] = 16'h0F0F;
    mem[12'h43] = 16'h3C3C;
    go(400, cyc);
    check("R3", "ADD low sum", mem[12'h50], 16'h0001);
    check("R3", "ADD carry out", mem[12'h51], 16'h0001);
    check("R2", "LDA then AND", mem[12'h52], 16'h0C0C);
    check("R3", "ADD no carry clears flag", mem[12'h53], 16'h3636);
  endtask

  task automatic t_indirect();
    int cyc;
    begin_prog();
    mem[0] = 16'hA050;  // LDA indirect via 50
    mem[1] = 16'hB051;  // STA indirect via 51
    mem[2] = 16'h7001;
    mem[12'h50]  = 16'hF120;
    mem[12'h51]  = 16'h0130;
    mem[12'h120] = 16'h1234;
    go(200, cyc);
    check("R4", "indirect load/store", mem[12'h130], 16'h1234);
    check("R5", "pointer word unchanged", mem[12'h50], 16'hF120);
  endtask

  task automatic t_branch();
    int cyc;
    begin_prog();
    mem[0]  = 16'h4010; // BUN 10
    mem[1]  = 16'h2040;
    mem[2]  = 16'h3041; // must be passed over
    mem[3]  = 16'h7001;
    mem[12'h10] = 16'h5020; // BSA 20
    mem[12'h11] = 16'h2042;
    mem[12'h12] = 16'h3043;
    mem[12'h13] = 16'h7001;
    mem[12'h21] = 16'h2044;
    mem[12'h22] = 16'h3045;
    mem[12'h23] = 16'hC020; // BUN indirect via 20 (return)
    mem[12'h40] = 16'h1111;
    mem[12'h42] = 16'h2222;
    mem[12'h44] = 16'h3333;
    go(400, cyc);
    check("R6", "branch skipped straight-line code", mem[12'h41], 16'h0000);
    check("R7", "return address stored", mem[12'h20], 16'h0011);
    check("R7", "subroutine body ran", mem[12'h45], 16'h3333);
    check("R6", "return via indirect branch", mem[12'h43], 16'h2222);
  endtask

  task automatic t_isz();
    int cyc;
    begin_prog();
    mem[0] = 16'h2070;
    mem[1] = 16'h6060; // wraps to 0, skip
    mem[2] = 16'h3071; // skipped
    mem[3] = 16'h6061; // 5 -> 6, no skip
    mem[4] = 16'h3072;
    mem[5] = 16'h7001;
    mem[12'h60] = 16'hFFFF;
    mem[12'h61] = 16'h0005;
    mem[12'h70] = 16'hAAAA;
    go(300, cyc);
    check("R8", "wrap to zero", mem[12'h60], 16'h0000);
    check("R8", "zero result skips", mem[12'h71], 16'h0000);
    check("R8", "plain increment", mem[12'h61], 16'h0006);
    check("R8", "nonzero result does not skip", mem[12'h72], 16'hAAAA);
  endtask

  task automatic t_regops();
    int cyc;
    logic [15:0] prog [23];
    prog = '{16'h2040, 16'h7080, 16'h3050, 16'h7040, 16'h3051, 16'h7200,
             16'h3052, 16'h7020, 16'h3053, 16'h7800, 16'h7100, 16'h7080,
             16'h3054, 16'h7100, 16'h7400, 16'h7040, 16'h3055, 16'h7800,
             16'h7200, 16'h7020, 16'h7080, 16'h3056, 16'h7001};
    begin_prog();
    for (int i = 0; i < 23; i++) mem[i] = prog[i];
    mem[12'h40] = 16'h8001;
    go(400, cyc);
    check("R9", "rotate right", mem[12'h50], 16'h4000);
    check("R9", "rotate left", mem[12'h51], 16'h8001);
    check("R9", "complement", mem[12'h52], 16'h7FFE);
    check("R9", "increment", mem[12'h53], 16'h7FFF);
    check("R9", "clear AC, complement carry", mem[12'h54], 16'h8000);
    check("R9", "clear carry", mem[12'h55], 16'h0000);
    check("R9", "increment keeps carry", mem[12'h56], 16'h8000);
  endtask

  task automatic t_skips();
    int cyc;
    logic [15:0] prog [20];
    logic [15:0] exp [8];
    prog = '{16'h7800, 16'h7004, 16'h6080, 16'h7010, 16'h6081, 16'h7008,
             16'h6082, 16'h7200, 16'h7004, 16'h6083, 16'h7008, 16'h6084,
             16'h7010, 16'h6085, 16'h7400, 16'h7002, 16'h6086, 16'h7100,
             16'h7002, 16'h6087};
    exp = '{16'd1, 16'd1, 16'd2, 16'd2, 16'd1, 16'd2, 16'd1, 16'd2};
    begin_prog();
    for (int i = 0; i < 20; i++) mem[i] = prog[i];
    mem[20] = 16'h7001;
    for (int i = 0; i < 8; i++) mem[12'h80 + i] = 16'h0001;
    go(600, cyc);
    for (int i = 0; i < 8; i++)
      check("R10", $sformatf("skip counter %0d", i), mem[12'h80 + i], exp[i]);
  endtask

  task automatic t_io();
    int cyc;
    begin_prog();
    inpData = 8'h5A;
    inpFlag = 1'b1;
    outFlag = 1'b0;
    mem[0]  = 16'h7800;
    mem[1]  = 16'h7200; // AC = FFFF
    mem[2]  = 16'hF800; // INP
    mem[3]  = 16'h3050;
    mem[4]  = 16'hF200; // SKI taken
    mem[5]  = 16'h6080;
    mem[6]  = 16'hF100; // SKO not taken
    mem[7]  = 16'h6081;
    mem[8]  = 16'hF400; // OUT
    mem[9]  = 16'hF080; // ION
    mem[10] = 16'h7001;
    mem[12'h80] = 16'h0001;
    mem[12'h81] = 16'h0001;
    go(400, cyc);
    check("R12", "input into low byte", mem[12'h50], 16'hFF5A);
    check("R12", "input-ready skip", mem[12'h80], 16'h0001);
    check("R12", "output-ready no skip", mem[12'h81], 16'h0002);
    check("R12", "output character", {8'h0, outData}, 16'h005A);
    check("R12", "interrupts enabled", {15'b0, intEnable}, 16'h0001);
    check("R12", "inpAck pulses", ackCnt[15:0], 16'd1);
    check("R12", "outStrobe pulses", strbCnt[15:0], 16'd1);

    begin_prog();
    inpFlag = 1'b0;
    outFlag = 1'b1;
    mem[0] = 16'hF080;
    mem[1] = 16'hF040; // IOF
    mem[2] = 16'hF100; // SKO taken
    mem[3] = 16'h6080;
    mem[4] = 16'hF200; // SKI not taken
    mem[5] = 16'h6081;
    mem[6] = 16'h7001;
    mem[12'h80] = 16'h0001;
    mem[12'h81] = 16'h0001;
    go(300, cyc);
    check("R12", "interrupts disabled", {15'b0, intEnable}, 16'h0000);
    check("R12", "output-ready skip", mem[12'h80], 16'h0001);
    check("R12", "input not ready", mem[12'h81], 16'h0002);
  endtask

  initial begin
    t_reset_halt();
    t_direct();
    t_indirect();
    t_branch();
    t_isz();
    t_regops();
    t_skips();
    t_io();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule